// File: doc/BRIEF.md
# Programmable Bit-Clock and Frame-Sync Generator

This block sits on the clock-master side of an audio serial port. It divides a fast system clock down to a serial bit clock and, on top of that bit clock, produces a periodic frame-sync pulse. The divider ratio, the frame length, the width of the sync pulse and the periodic-generation enable all come from one configuration word. Two polarity bits choose the active level of the sync pulse and the bit-clock edge on which a downstream serializer should launch data.

Bring-up follows a fixed order. The generator release starts the divider first. The frame-sync release is raised once the bit clock is running, and the first frame then starts on the next bit boundary. The block also provides two single-cycle strobes:
- a frame-start strobe that marks bit 0 of every frame;
- a launch strobe that marks the chosen bit-clock edge.

A serializer can use these strobes instead of detecting edges itself. A new configuration takes effect only at a frame boundary. While the frame sync is idle, it takes effect at the next bit boundary. While the generator is held, it takes effect at once. No partial frame is therefore emitted.

Top module: `bclk_fs_gen`

## Requirements
- R1: `gen_cfg[7:0]` holds the divider value D. The bit clock repeats every D+1 system clocks, and a value of 0 acts as 1. In each bit, the bit clock is high for the first floor(D/2)+1 cycles, starting at its rising edge.
- R2: `gen_cfg[27:16]` holds P. A frame lasts P+1 bit clocks, so frame-start strobes are (P+1)*(D+1) system clocks apart.
- R3: `gen_cfg[15:8]` holds W. The frame sync is active for the first W+1 bits of every frame, and for the whole frame when W >= P.
- R4: When `gen_cfg[28]` is 0, the frame sync stays at its inactive level and no frame-start strobe is produced.
- R5: While `gen_go` is low, the bit clock is low and both strobes are low. In the first cycle after `gen_go` is seen high, the bit clock goes high.
- R6: While `fs_go` is low, the frame sync is inactive and no frame-start strobe occurs, while the bit clock keeps running. After `fs_go` rises, the first frame starts at the next bit boundary.
- R7: `pin_cfg[1]` sets the frame-sync polarity: 1 means active low (idle high) and 0 means active high (idle low).
- R8: `pin_cfg[0]` selects the launch edge. When it is 0, `shift_stb_o` pulses in the first cycle the bit clock is high. When it is 1, it pulses in the first cycle the bit clock is low.
- R9: `frame_start_o` is high for exactly one cycle, and that cycle is the first high cycle of bit 0 of the frame.
- R10: A configuration change during a running frame has no effect until that frame ends. The new values apply from the next frame on.
- R11: A synchronous active-high `rst` returns the bit clock and both strobes to low, and the frame sync to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_go | input | 1 | Generator release: runs the divider |
| fs_go | input | 1 | Frame-sync release |
| gen_cfg | input | 29 | Divider [7:0], sync width [15:8], frame period [27:16], periodic enable [28] |
| pin_cfg | input | 2 | Launch edge [0], frame-sync polarity [1] |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame-sync pulse |
| frame_start_o | output | 1 | One-cycle strobe at bit 0 of each frame |
| shift_stb_o | output | 1 | One-cycle strobe on the selected bit-clock edge |

## Verification
Every output is a register, so each one answers an input change at the very next clock edge. The first high bit clock after release, the idle levels after the two releases drop, and the reset state are all sampled one cycle after the input moves. A configuration write is due only after the current frame ends. The bench therefore measures the gap between frame-start strobes: the gap after a mid-frame write must still be the old length, and the gap after that must be the new one. A behavioural model advances on every clock edge and is compared at the falling edge, so each output is checked in exactly the cycle it is due.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int DIV_W     = 8;
  localparam int WID_W     = 8;
  localparam int PER_W     = 12;
  localparam int WID_LSB   = DIV_W;
  localparam int PER_LSB   = DIV_W + WID_W;
  localparam int EN_BIT    = PER_LSB + PER_W;
  localparam int CFG_W     = EN_BIT + 1;
  localparam int PIN_W     = 2;
  localparam int PIN_EDGE  = 0;
  localparam int PIN_FSPOL = 1;

  typedef struct packed {
    logic             per_en;
    logic [PER_W-1:0] per;
    logic [WID_W-1:0] wid;
    logic [DIV_W-1:0] div;
    logic             fs_pol;
    logic             ck_pol;
  } bfg_cfg_t;

  // divider value zero is promoted to one so the bit clock never exceeds clk/2
  function automatic bfg_cfg_t bfg_unpack(input logic [CFG_W-1:0] c,
                                          input logic [PIN_W-1:0] p);
    bfg_cfg_t r;
    r.div    = (c[DIV_W-1:0] == '0) ? DIV_W'(1) : c[DIV_W-1:0];
    r.wid    = c[WID_LSB +: WID_W];
    r.per    = c[PER_LSB +: PER_W];
    r.per_en = c[EN_BIT];
    r.ck_pol = p[PIN_EDGE];
    r.fs_pol = p[PIN_FSPOL];
    return r;
  endfunction
endpackage

// File: rtl/bfg_bit_div.sv
module bfg_bit_div import bfg_pkg::*; (
  input  logic             clk,
  input  logic             active,
  input  logic [DIV_W-1:0] div_cur,
  input  logic [DIV_W-1:0] div_nxt,
  input  logic             ck_pol_nxt,
  output logic             run_q,
  output logic             wrap,
  output logic             bclk_o,
  output logic             shift_stb_o
);
  logic [DIV_W-1:0] ph_q;
  logic [DIV_W-1:0] ph_nx;
  logic [DIV_W-1:0] half;

  assign wrap  = run_q && (ph_q == div_cur);
  assign ph_nx = wrap ? '0 : ph_q + DIV_W'(1);
  assign half  = div_nxt >> 1;

  always_ff @(posedge clk) begin
    if (!active) begin
      run_q       <= 1'b0;
      ph_q        <= '0;
      bclk_o      <= 1'b0;
      shift_stb_o <= 1'b0;
    end else if (!run_q) begin
      run_q       <= 1'b1;
      ph_q        <= '0;
      bclk_o      <= 1'b1;
      shift_stb_o <= !ck_pol_nxt;
    end else begin
      ph_q        <= ph_nx;
      bclk_o      <= (ph_nx <= half);
      shift_stb_o <= ck_pol_nxt ? (ph_nx == half + DIV_W'(1)) : (ph_nx == '0);
    end
  end
endmodule

// File: rtl/bfg_frame_ctr.sv
module bfg_frame_ctr import bfg_pkg::*; (
  input  logic             clk,
  input  logic             active,
  input  logic             fs_go,
  input  logic             run_q,
  input  logic             wrap,
  input  logic [PER_W-1:0] per_cur,
  input  logic             per_en_nxt,
  input  logic [WID_W-1:0] wid_nxt,
  input  logic             fs_pol_nxt,
  output logic             frame_begin,
  output logic             fsrun_nx,
  output logic             frame_start_o,
  output logic             fsync_o
);
  logic             fsrun_q;
  logic [PER_W-1:0] bit_q;
  logic [PER_W-1:0] bit_nx;
  logic             fs_active;

  assign fsrun_nx    = active && fs_go && run_q && (fsrun_q || wrap);
  assign frame_begin = wrap && fsrun_nx && (!fsrun_q || (bit_q == per_cur));
  assign bit_nx      = (!fsrun_nx || frame_begin) ? '0 :
                       (wrap ? bit_q + PER_W'(1) : bit_q);
  assign fs_active   = fsrun_nx && per_en_nxt && (bit_nx <= PER_W'(wid_nxt));

  always_ff @(posedge clk) begin
    fsrun_q       <= fsrun_nx;
    bit_q         <= bit_nx;
    frame_start_o <= frame_begin && per_en_nxt;
    fsync_o       <= fs_active ^ fs_pol_nxt;
  end
endmodule

// File: rtl/bclk_fs_gen.sv
module bclk_fs_gen import bfg_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_go,
  input  logic             fs_go,
  input  logic [CFG_W-1:0] gen_cfg,
  input  logic [PIN_W-1:0] pin_cfg,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             frame_start_o,
  output logic             shift_stb_o
);
  bfg_cfg_t sh_q;
  bfg_cfg_t sh_nx;
  logic     active;
  logic     run_q;
  logic     wrap;
  logic     frame_begin;
  logic     fsrun_nx;
  logic     load;

  assign active = !rst && gen_go;
  // shadow refreshes while held, at start-up, at frame starts, or at bit ends with sync idle
  assign load   = !active || !run_q || (wrap && (frame_begin || !fsrun_nx));
  assign sh_nx  = load ? bfg_unpack(gen_cfg, pin_cfg) : sh_q;

  always_ff @(posedge clk) begin
    sh_q <= sh_nx;
  end

  bfg_bit_div u_div (
    .clk        (clk),
    .active     (active),
    .div_cur    (sh_q.div),
    .div_nxt    (sh_nx.div),
    .ck_pol_nxt (sh_nx.ck_pol),
    .run_q      (run_q),
    .wrap       (wrap),
    .bclk_o     (bclk_o),
    .shift_stb_o(shift_stb_o)
  );

  bfg_frame_ctr u_frm (
    .clk          (clk),
    .active       (active),
    .fs_go        (fs_go),
    .run_q        (run_q),
    .wrap         (wrap),
    .per_cur      (sh_q.per),
    .per_en_nxt   (sh_nx.per_en),
    .wid_nxt      (sh_nx.wid),
    .fs_pol_nxt   (sh_nx.fs_pol),
    .frame_begin  (frame_begin),
    .fsrun_nx     (fsrun_nx),
    .frame_start_o(frame_start_o),
    .fsync_o      (fsync_o)
  );
endmodule

// File: rtl/bclk_fs_gen_chk.sv
module bclk_fs_gen_chk (
  input logic clk,
  input logic rst,
  input logic gen_go,
  input logic fs_go,
  input logic bclk_o,
  input logic frame_start_o,
  input logic shift_stb_o
);
  // R5: generator held means quiet clock and strobes next cycle
  p_gen_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !gen_go |=> (!bclk_o && !frame_start_o && !shift_stb_o));

  // R6: frame sync held means no frame start next cycle
  p_fs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !fs_go |=> !frame_start_o);

  // R9: frame start lands on the first high cycle of the bit clock
  p_start_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (bclk_o && !$past(bclk_o)));

  // R9: frame start lasts a single cycle
  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);
endmodule

bind bclk_fs_gen bclk_fs_gen_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .gen_go       (gen_go),
  .fs_go        (fs_go),
  .bclk_o       (bclk_o),
  .frame_start_o(frame_start_o),
  .shift_stb_o  (shift_stb_o)
);

// File: tb/test_bclk_fs_gen.sv
module test_bclk_fs_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_go = 1'b0;
  logic        fs_go = 1'b0;
  logic [28:0] cfg;
  logic [1:0]  pin = 2'b00;
  logic        bclk_o, fsync_o, frame_start_o, shift_stb_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_fs = 0;

  // reference model state
  int m_run = 0, m_fr = 0, m_ph = 0, m_bi = 0;
  int m_d = 1, m_w = 0, m_p = 0, m_en = 0, m_cp = 0, m_fp = 0;
  int e_bclk = 0, e_fs = 0, e_fst = 0, e_stb = 0;

  always #(CLK_P/2) clk = ~clk;

  bclk_fs_gen i_bclk_fs_gen (
    .clk(clk), .rst(rst), .gen_go(gen_go), .fs_go(fs_go),
    .gen_cfg(cfg), .pin_cfg(pin),
    .bclk_o(bclk_o), .fsync_o(fsync_o),
    .frame_start_o(frame_start_o), .shift_stb_o(shift_stb_o)
  );

  function automatic logic [28:0] mk(input int en, input int p, input int w, input int d);
    logic [28:0] v;
    v[28]    = en[0];
    v[27:16] = p[11:0];
    v[15:8]  = w[7:0];
    v[7:0]   = d[7:0];
    return v;
  endfunction

  task automatic take_cfg();
    m_d  = (cfg[7:0] == 0) ? 1 : int'(cfg[7:0]);
    m_w  = int'(cfg[15:8]);
    m_p  = int'(cfg[27:16]);
    m_en = int'(cfg[28]);
    m_cp = int'(pin[0]);
    m_fp = int'(pin[1]);
  endtask

  always @(posedge clk) begin
    int end_bit;
    int newf;
    cyc++;
    if (rst || !gen_go) begin
      m_run = 0; m_fr = 0; m_ph = 0; m_bi = 0;
      take_cfg();
      e_bclk = 0; e_stb = 0; e_fst = 0; e_fs = m_fp;
    end else if (m_run == 0) begin
      m_run = 1; m_ph = 0; m_fr = 0; m_bi = 0;
      take_cfg();
      e_bclk = 1; e_stb = (m_cp == 0); e_fst = 0; e_fs = m_fp;
    end else begin
      end_bit = (m_ph == m_d);
      newf = 0;
      if (!fs_go) begin
        m_fr = 0; m_bi = 0;
      end else if (end_bit) begin
        if (m_fr == 0) begin m_fr = 1; m_bi = 0; newf = 1; end
        else if (m_bi == m_p) begin m_bi = 0; newf = 1; end
        else m_bi++;
      end
      if (end_bit && (newf || m_fr == 0)) take_cfg();
      m_ph   = end_bit ? 0 : m_ph + 1;
      e_bclk = (m_ph <= m_d / 2);
      e_stb  = m_cp ? (m_ph == m_d / 2 + 1) : (m_ph == 0);
      e_fst  = newf && m_en;
      e_fs   = (m_fr && m_en && m_bi <= m_w) ? !m_fp : m_fp;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(int'(bclk_o) == e_bclk, "R1 bit clock vs model", int'(bclk_o), e_bclk);
      chk(int'(fsync_o) == e_fs, "R3 frame sync vs model", int'(fsync_o), e_fs);
      chk(int'(frame_start_o) == e_fst, "R9 frame start vs model", int'(frame_start_o), e_fst);
      chk(int'(shift_stb_o) == e_stb, "R8 launch strobe vs model", int'(shift_stb_o), e_stb);
    end
  end

  task automatic wait_fs(output int gap);
    do @(negedge clk); while (!frame_start_o);
    gap = cyc - last_fs;
    last_fs = cyc;
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (fsync_o == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic edge_scan(input int cycles, input bit falling, output int hits, output int bad);
    logic prev;
    hits = 0; bad = 0;
    for (int i = 0; i < cycles; i++) begin
      prev = bclk_o;
      @(negedge clk);
      if (shift_stb_o) begin
        hits++;
        if (falling ? !(bclk_o == 1'b0 && prev == 1'b1) : !(bclk_o == 1'b1 && prev == 1'b0)) bad++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g, n, h, b, viol, rises;
    logic prev;
    cfg = mk(1, 7, 0, 3);
    repeat (4) @(negedge clk);
    chk(bclk_o == 0 && fsync_o == 0 && frame_start_o == 0 && shift_stb_o == 0,
        "R11 reset idle", int'(bclk_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(bclk_o == 0 && shift_stb_o == 0, "R5 held generator quiet", int'(bclk_o), 0);

    gen_go = 1'b1;
    @(negedge clk);
    chk(bclk_o == 1, "R5 first cycle after release high", int'(bclk_o), 1);
    count_level_bclk: begin
      n = 0;
      while (bclk_o) begin n++; @(negedge clk); end
      chk(n == 2, "R1 high cycles D=3", n, 2);
      n = 0;
      while (!bclk_o) begin n++; @(negedge clk); end
      chk(n == 2, "R1 low cycles D=3", n, 2);
    end
    edge_scan(24, 1'b0, h, b);
    chk(h == 6 && b == 0, "R8 rising launch strobes", h, 6);

    fs_go = 1'b1;
    wait_fs(g);
    wait_fs(g);
    chk(g == 32, "R2 frame gap P=7 D=3", g, 32);
    count_level(1'b1, n);
    chk(n == 4, "R3 sync width W=0", n, 4);

    repeat (5) @(negedge clk);
    cfg = mk(1, 5, 2, 4);
    wait_fs(g);
    chk(g == 32, "R10 running frame keeps old length", g, 32);
    count_level(1'b1, n);
    chk(n == 15, "R3 sync width W=2 D=4", n, 15);
    wait_fs(g);
    chk(g == 30, "R10 new length from next frame", g, 30);

    gen_go = 1'b0;
    pin = 2'b11;
    repeat (2) @(negedge clk);
    chk(fsync_o == 1, "R7 idle high when active low", int'(fsync_o), 1);
    chk(bclk_o == 0, "R5 generator dropped", int'(bclk_o), 0);
    gen_go = 1'b1;
    wait_fs(g);
    chk(fsync_o == 0, "R7 active low pulse", int'(fsync_o), 0);
    edge_scan(40, 1'b1, h, b);
    chk(h == 8 && b == 0, "R8 falling launch strobes", h, 8);

    cfg = mk(0, 5, 2, 4);
    repeat (80) @(negedge clk);
    viol = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (frame_start_o || fsync_o != 1'b1) viol++;
    end
    chk(viol == 0, "R4 periodic disabled", viol, 0);

    gen_go = 1'b0; fs_go = 1'b0;
    cfg = mk(1, 3, 7, 0);
    pin = 2'b00;
    repeat (2) @(negedge clk);
    gen_go = 1'b1;
    repeat (3) @(negedge clk);
    fs_go = 1'b1;
    wait_fs(g);
    wait_fs(g);
    chk(g == 8, "R1 divider zero acts as one", g, 8);
    viol = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (fsync_o != 1'b1) viol++;
    end
    chk(viol == 0, "R3 width beyond period holds sync", viol, 0);

    fs_go = 1'b0;
    @(negedge clk);
    chk(fsync_o == 0, "R6 sync idle after release drop", int'(fsync_o), 0);
    viol = 0; rises = 0;
    for (int i = 0; i < 20; i++) begin
      prev = bclk_o;
      @(negedge clk);
      if (frame_start_o || fsync_o) viol++;
      if (bclk_o && !prev) rises++;
    end
    chk(viol == 0 && rises > 0, "R6 clock runs while sync held", viol, 0);
    fs_go = 1'b1;
    do begin prev = bclk_o; @(negedge clk); end while (!frame_start_o);
    chk(bclk_o == 1 && prev == 0, "R9 frame start on rising bit clock", int'(prev), 0);

    rst = 1'b1;
    @(negedge clk);
    chk(bclk_o == 0 && fsync_o == 0 && frame_start_o == 0 && shift_stb_o == 0,
        "R11 reset mid-run", int'(bclk_o), 0);
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule